// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one pulse-width-modulation timer channel. A 24-bit up-counter runs on a dedicated PWM clock. A prescaler divides that clock by 1, 16, 256 or 2048 before the counter sees it. The counter runs from zero up to a programmed period value and then clears. The output is active while the count is below a programmed duty value. A polarity bit swaps the active and inactive levels.

Software sets up the channel through a plain register bus on its own bus clock. That clock has no fixed relation to the PWM clock, and either one may be the faster. Configuration words cross into the counter domain as whole words through a request/acknowledge handshake. Event flags come back the same way. The counter domain loads new settings into its working copies only when the counter clears, so a period that is already running is never altered.

Three event sources share one level interrupt: the output's rising edge, its falling edge, and the counter clearing. Each source has a sticky status bit and an enable bit. The register bus carries plain control and status traffic and has no back-pressure: every access completes in the cycle it is presented.

Top module: `pwm_chan_top`

## Requirements
- R1: After both resets, `pwm_out` and `irq` are low and every register reads 0.
- R2: Register map, by word address: 0 = control (bit0 enable, bit1 invert, bits3:2 divider select); 1 = period (24 bits); 2 = duty (24 bits); 3 = interrupt enable (3 bits); 4 = interrupt status (3 bits). Unused upper bits read 0. A write takes effect when `bus_sel` and `bus_wr` are high at a `bus_clk` edge. `bus_rdata` shows the addressed register combinationally.
- R3: Divider select 0, 1, 2 and 3 gives a count step every 1, 16, 256 and 2048 PWM clocks, so one output period lasts (period+1) × divider PWM clocks.
- R4: With 0 < duty < period, the output is active for duty × divider PWM clocks at the start of each period. The output comes from a register.
- R5: Duty 0 keeps the output inactive at all times. A nonzero duty at or above the period keeps it active at all times. Neither case produces an edge.
- R6: With invert = 1 the active level is 0 and the inactive level is 1. With invert = 0 it is the other way round.
- R7: While the enable bit is 0, the counter and prescaler are held at zero and the output drives the inactive level.
- R8: Period, duty, invert and divider select are loaded into the working copies only while the channel is disabled or when the counter clears. The count never exceeds the working period.
- R9: Status bit0 records an output rising edge, bit1 a falling edge and bit2 a counter clear, each while the channel is enabled. A set bit stays set until software clears it.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it alone. An event that arrives in the same cycle as the clear leaves the bit set.
- R11: `irq` is a registered OR of the status bits whose enable bits are set.
- R12: Configuration crosses to the PWM clock as a whole word. Writes made while a transfer is in flight are merged, and the latest register values are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Bus domain reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt, bus domain |
| pwm_clk | input | 1 | Counter clock |
| pwm_rst_n | input | 1 | Counter domain reset, active low |
| pwm_out | output | 1 | PWM waveform |

## Verification
Several properties are checked by assertions on every clock edge:
- the count never exceeds the working period;
- the working period and duty stay put once a period is under way;
- the output holds its level when disabled, at duty 0 and at full duty;
- status bits stay sticky, and an arriving event beats a same-cycle clear;
- `irq` tracks the enabled pending bits.

Other behaviour can only be shown by the bench scenarios:
- exact high times and period lengths for each divider;
- the swap of levels under inversion;
- a duty change applied while the channel runs;
- the separate status bits;
- partial write-one-to-clear.

Both of these scenario groups run with the two clocks at unrelated rates.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int CTRL_W = 4;     // enable, invert, divider select[1:0]
  localparam int NEV    = 3;     // event sources
  localparam int PRE_W  = 11;    // prescaler width, covers divide by 2048

  localparam int BIT_EN  = 0;
  localparam int BIT_INV = 1;
  localparam int BIT_SEL = 2;

  localparam int EV_RISE = 0;
  localparam int EV_FALL = 1;
  localparam int EV_CLR  = 2;

  localparam int REG_CTRL   = 0;
  localparam int REG_PERIOD = 1;
  localparam int REG_DUTY   = 2;
  localparam int REG_IEN    = 3;
  localparam int REG_STAT   = 4;

  typedef enum logic [1:0] {DIV_1 = 2'd0, DIV_16 = 2'd1, DIV_256 = 2'd2, DIV_2048 = 2'd3} div_sel_e;

  function automatic int div_shift(input logic [1:0] sel);
    case (div_sel_e'(sel))
      DIV_1:    return 0;
      DIV_16:   return 4;
      DIV_256:  return 8;
      default:  return 11;
    endcase
  endfunction
endpackage

// File: rtl/pwm_cdc_word.sv
`timescale 1ns/1ps
// Moves a whole word from one clock domain to another with toggle request/acknowledge.
module pwm_cdc_word #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  output logic         src_take,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data,
  output logic         dst_valid
);
  logic            req_t, pend, busy;
  logic [W-1:0]    hold;
  logic [SYNC-1:0] ack_sync, req_sync;
  logic            req_seen, ack_t;

  assign busy     = req_t != ack_sync[SYNC-1];
  assign src_take = (src_load | pend) & ~busy;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_t    <= 1'b0;
      pend     <= 1'b0;
      hold     <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC-2:0], ack_t};
      if (src_take) begin
        hold  <= src_data;
        req_t <= ~req_t;
        pend  <= 1'b0;
      end else if (src_load) begin
        pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_sync  <= '0;
      req_seen  <= 1'b0;
      ack_t     <= 1'b0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      req_sync  <= {req_sync[SYNC-2:0], req_t};
      req_seen  <= req_sync[SYNC-1];
      ack_t     <= req_sync[SYNC-1];
      dst_valid <= req_sync[SYNC-1] != req_seen;
      if (req_sync[SYNC-1] != req_seen) dst_data <= hold;
    end
  end
endmodule

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs import pwm_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [2*CNT_W+CTRL_W-1:0] cfg_word,
  output logic                      cfg_load,
  input  logic                      ev_valid,
  input  logic [NEV-1:0]            ev_bits,
  output logic [NEV-1:0]            stat,
  output logic [NEV-1:0]            ien,
  output logic                      irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  per_q, duty_q;
  logic [NEV-1:0]    ien_n, stat_n, clr;
  logic              wr_hit;
  logic              unused_wdata_hi;

  assign wr_hit = sel & wr;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

  always_comb begin
    ien_n = ien;
    clr   = '0;
    if (wr_hit && addr == ADDR_W'(REG_IEN))  ien_n = wdata[NEV-1:0];
    if (wr_hit && addr == ADDR_W'(REG_STAT)) clr   = wdata[NEV-1:0];
    stat_n = (stat & ~clr) | (ev_valid ? ev_bits : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      per_q    <= '0;
      duty_q   <= '0;
      ien      <= '0;
      stat     <= '0;
      irq      <= 1'b0;
      cfg_load <= 1'b0;
    end else begin
      if (wr_hit && addr == ADDR_W'(REG_CTRL))   ctrl_q <= wdata[CTRL_W-1:0];
      if (wr_hit && addr == ADDR_W'(REG_PERIOD)) per_q  <= wdata[CNT_W-1:0];
      if (wr_hit && addr == ADDR_W'(REG_DUTY))   duty_q <= wdata[CNT_W-1:0];
      ien      <= ien_n;
      stat     <= stat_n;
      irq      <= |(stat_n & ien_n);
      // one cycle late, so the transfer picks up the value just written
      cfg_load <= wr_hit && (addr == ADDR_W'(REG_CTRL) || addr == ADDR_W'(REG_PERIOD) ||
                             addr == ADDR_W'(REG_DUTY));
    end
  end

  assign cfg_word = {duty_q, per_q, ctrl_q};

  always_comb begin
    case (addr)
      ADDR_W'(REG_CTRL):   rdata = DATA_W'(ctrl_q);
      ADDR_W'(REG_PERIOD): rdata = DATA_W'(per_q);
      ADDR_W'(REG_DUTY):   rdata = DATA_W'(duty_q);
      ADDR_W'(REG_IEN):    rdata = DATA_W'(ien);
      ADDR_W'(REG_STAT):   rdata = DATA_W'(stat);
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale import pwm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q, lim;

  assign lim  = PRE_W'((1 << div_shift(sel)) - 1);
  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_core.sv
`timescale 1ns/1ps
module pwm_core import pwm_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*CNT_W+CTRL_W-1:0] cfg,
  input  logic                      ev_take,
  output logic [NEV-1:0]            ev_acc,
  output logic                      pwm_out,
  output logic                      run,
  output logic                      inv_a,
  output logic [CNT_W-1:0]          cnt_q,
  output logic [CNT_W-1:0]          per_a,
  output logic [CNT_W-1:0]          duty_a
);
  logic [1:0]     sel_a;
  logic           tick, wrap, load, raw, out_n;
  logic [NEV-1:0] ev_n;

  assign run  = cfg[BIT_EN];
  assign wrap = cnt_q >= per_a;
  assign load = !run || (tick && wrap);

  pwm_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel_a),
    .tick (tick)
  );

  // duty 0 wins over the full-duty rule
  assign raw   = (duty_a != '0) && ((duty_a >= per_a) || (cnt_q < duty_a));
  assign out_n = run ? (raw ^ inv_a) : inv_a;

  always_comb begin
    ev_n          = '0;
    ev_n[EV_RISE] = run &&  out_n && !pwm_out;
    ev_n[EV_FALL] = run && !out_n &&  pwm_out;
    ev_n[EV_CLR]  = run && tick && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_a   <= '0;
      duty_a  <= '0;
      inv_a   <= 1'b0;
      sel_a   <= '0;
      pwm_out <= 1'b0;
      ev_acc  <= '0;
    end else begin
      if (load) begin
        per_a  <= cfg[CTRL_W +: CNT_W];
        duty_a <= cfg[CTRL_W+CNT_W +: CNT_W];
        inv_a  <= cfg[BIT_INV];
        sel_a  <= cfg[BIT_SEL +: 2];
      end
      if (!run)      cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      pwm_out <= out_n;
      ev_acc  <= (ev_take ? '0 : ev_acc) | ev_n;
    end
  end
endmodule

// File: rtl/pwm_chan_top.sv
`timescale 1ns/1ps
module pwm_chan_top import pwm_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int SYNC   = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              pwm_clk,
  input  logic              pwm_rst_n,
  output logic              pwm_out
);
  localparam int CFG_W = 2*CNT_W + CTRL_W;

  logic [CFG_W-1:0] cfg_bus, cfg_pwm;
  logic             cfg_load, cfg_take_unused, cfg_valid_unused;
  logic [NEV-1:0]   ev_acc, evx_bits, stat_w, ien_w;
  logic             ev_take, evx_valid;
  logic             core_en, core_inv;
  logic [CNT_W-1:0] core_cnt, core_per, core_duty;

  pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .cfg_word(cfg_bus),
    .cfg_load(cfg_load),
    .ev_valid(evx_valid),
    .ev_bits (evx_bits),
    .stat    (stat_w),
    .ien     (ien_w),
    .irq     (irq)
  );

  pwm_cdc_word #(.W(CFG_W), .SYNC(SYNC)) u_cfg_x (
    .src_clk  (bus_clk),
    .src_rst_n(bus_rst_n),
    .src_load (cfg_load),
    .src_data (cfg_bus),
    .src_take (cfg_take_unused),
    .dst_clk  (pwm_clk),
    .dst_rst_n(pwm_rst_n),
    .dst_data (cfg_pwm),
    .dst_valid(cfg_valid_unused)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk    (pwm_clk),
    .rst_n  (pwm_rst_n),
    .cfg    (cfg_pwm),
    .ev_take(ev_take),
    .ev_acc (ev_acc),
    .pwm_out(pwm_out),
    .run    (core_en),
    .inv_a  (core_inv),
    .cnt_q  (core_cnt),
    .per_a  (core_per),
    .duty_a (core_duty)
  );

  pwm_cdc_word #(.W(NEV), .SYNC(SYNC)) u_ev_x (
    .src_clk  (pwm_clk),
    .src_rst_n(pwm_rst_n),
    .src_load (|ev_acc),
    .src_data (ev_acc),
    .src_take (ev_take),
    .dst_clk  (bus_clk),
    .dst_rst_n(bus_rst_n),
    .dst_data (evx_bits),
    .dst_valid(evx_valid)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
`timescale 1ns/1ps
module pwm_chan_chk import pwm_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              pwm_clk,
  input logic              pwm_rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic [NEV-1:0]    stat,
  input logic [NEV-1:0]    ien,
  input logic              ev_valid,
  input logic [NEV-1:0]    ev_bits,
  input logic              pwm_out,
  input logic              core_en,
  input logic              core_inv,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per_a,
  input logic [CNT_W-1:0]  duty_a
);
  logic [NEV-1:0] clr_mask;
  assign clr_mask = (bus_sel && bus_wr && bus_addr == ADDR_W'(REG_STAT)) ? bus_wdata[NEV-1:0] : '0;

  // R11
  irq_tracks_pending_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    irq == |(stat & ien));

  // R9
  status_sticky_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    ((($past(stat) & ~$past(clr_mask)) & ~stat) == '0));

  // R10
  event_beats_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    ev_valid |=> (($past(ev_bits) & ~stat) == '0));

  // R8
  count_in_range_chk: assert property (@(posedge pwm_clk) disable iff (!pwm_rst_n)
    cnt <= per_a);

  // R8
  shadow_held_chk: assert property (@(posedge pwm_clk) disable iff (!pwm_rst_n)
    (core_en && cnt != '0) |-> ($stable(per_a) && $stable(duty_a)));

  // R7
  idle_level_chk: assert property (@(posedge pwm_clk) disable iff (!pwm_rst_n)
    !core_en |=> (cnt == '0 && pwm_out == $past(core_inv)));

  // R5
  duty_zero_chk: assert property (@(posedge pwm_clk) disable iff (!pwm_rst_n)
    (core_en && duty_a == '0) |=> (pwm_out == $past(core_inv)));

  // R5
  duty_full_chk: assert property (@(posedge pwm_clk) disable iff (!pwm_rst_n)
    (core_en && duty_a != '0 && duty_a >= per_a) |=> (pwm_out != $past(core_inv)));
endmodule

bind pwm_chan_top pwm_chan_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .bus_clk  (bus_clk),
  .bus_rst_n(bus_rst_n),
  .pwm_clk  (pwm_clk),
  .pwm_rst_n(pwm_rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .stat     (stat_w),
  .ien      (ien_w),
  .ev_valid (evx_valid),
  .ev_bits  (evx_bits),
  .pwm_out  (pwm_out),
  .core_en  (core_en),
  .core_inv (core_inv),
  .cnt      (core_cnt),
  .per_a    (core_per),
  .duty_a   (core_duty)
);

// File: tb/pwm_chan_top_test.sv
`timescale 1ns/1ps
module pwm_chan_top_test;
  logic        bus_clk = 1'b0, pwm_clk = 1'b0;
  logic        bus_rst_n = 1'b0, pwm_rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, pwm_out;

  always #5   bus_clk = ~bus_clk;   // 100 MHz
  always #3.5 pwm_clk = ~pwm_clk;   // unrelated, faster

  pwm_chan_top uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .pwm_clk(pwm_clk), .pwm_rst_n(pwm_rst_n), .pwm_out(pwm_out)
  );

  typedef struct {
    int    kind;   // 0: one measured period, 1: level count over a window
    int    hi;
    int    len;
    logic  act;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0, done_cnt = 0;
  bit   finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge bus_clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge bus_clk);
    bus_addr = 3'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic setup(input int per, input int duty, input int sel, input int inv, input bit stop_first);
    if (stop_first) bus_write(0, (sel << 2) | (inv << 1));
    bus_write(1, per);
    bus_write(2, duty);
    bus_write(0, (sel << 2) | (inv << 1) | 1);
    idle(40);
  endtask

  // driver: pushes the expectation and waits for the monitor to consume it
  task automatic expect_item(input int kind, input int hi, input int len, input logic act, input string req);
    exp_t it;
    int target;
    it.kind = kind; it.hi = hi; it.len = len; it.act = act; it.req = req;
    target = done_cnt + 1;
    q.push_back(it);
    wait (done_cnt == target);
  endtask

  // monitor: measures the waveform in the PWM domain
  initial begin
    forever begin
      exp_t it;
      logic prev;
      int   hi, len;
      wait (q.size() != 0);
      it = q[0];
      if (it.kind == 0) begin
        prev = pwm_out;
        forever begin
          @(negedge pwm_clk);
          if (pwm_out == it.act && prev != it.act) break;
          prev = pwm_out;
        end
        hi = 1; len = 1; prev = pwm_out;
        forever begin
          @(negedge pwm_clk);
          if (pwm_out == it.act && prev != it.act) break;
          len++;
          if (pwm_out == it.act) hi++;
          prev = pwm_out;
        end
        check({it.req, " active time"}, hi, it.hi);
        check({it.req, " period length"}, len, it.len);
      end else begin
        hi = 0;
        for (int i = 0; i < it.len; i++) begin
          @(negedge pwm_clk);
          if (pwm_out == it.act) hi++;
        end
        check({it.req, " active count"}, hi, it.hi);
      end
      void'(q.pop_front());
      done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    idle(4);
    bus_rst_n = 1'b1; pwm_rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 5; a++) begin
      bus_read(a, d);
      check("R1 register reads zero", d, 0);
    end

    // R2 readback and field widths
    bus_write(1, 32'hABCDEF12); bus_read(1, d); check("R2 period width", d, 32'h00CDEF12);
    bus_write(2, 32'h12345678); bus_read(2, d); check("R2 duty width", d, 32'h00345678);
    bus_write(0, 32'hFE);       bus_read(0, d); check("R2 control width", d, 32'hE);
    bus_write(3, 32'hFF);       bus_read(3, d); check("R2 enable width", d, 7);
    bus_write(3, 0);
    bus_write(0, 0);
    idle(40);

    // R3 R4 waveform timing under each divider
    setup(9, 3, 0, 0, 1'b1); expect_item(0, 3, 10, 1'b1, "R4 R3 div1 duty3 per9");
    // R8 R12 duty change while running, picked up at a period boundary
    bus_write(2, 7); idle(40);
    expect_item(0, 7, 10, 1'b1, "R8 R12 live duty change");
    setup(4, 2, 1, 0, 1'b1); expect_item(0, 32, 80, 1'b1, "R3 div16");
    setup(2, 1, 2, 0, 1'b1); expect_item(0, 256, 768, 1'b1, "R3 div256");
    setup(3, 1, 3, 0, 1'b1); expect_item(0, 2048, 8192, 1'b1, "R3 div2048");
    // R6 inverted polarity: active level is low
    setup(7, 5, 0, 1, 1'b1); expect_item(0, 5, 8, 1'b0, "R6 inverted");
    // R5 boundaries
    setup(5, 0, 0, 0, 1'b1); expect_item(1, 0, 60, 1'b1, "R5 duty zero");
    setup(5, 5, 0, 0, 1'b1); expect_item(1, 60, 60, 1'b1, "R5 duty equals period");
    setup(5, 9, 0, 1, 1'b1); expect_item(1, 60, 60, 1'b0, "R5 R6 duty above period inverted");

    // R7 disabled level follows polarity
    bus_write(0, 2); idle(40); check("R7 R6 disabled inverted level", int'(pwm_out), 1);
    bus_write(0, 0); idle(40); check("R7 disabled level", int'(pwm_out), 0);

    // R9 R11 status and masking
    setup(9, 4, 0, 0, 1'b1);
    bus_write(4, 7);
    idle(100);
    bus_read(4, d); check("R9 all sources flagged", d, 7);
    check("R11 masked irq", int'(irq), 0);
    bus_write(3, 4); idle(2);
    check("R11 enabled irq", int'(irq), 1);
    // R10 write-one-to-clear, partial then full
    bus_write(0, 0); idle(50);
    bus_write(4, 1); bus_read(4, d); check("R10 partial clear", d, 6);
    check("R11 irq still pending", int'(irq), 1);
    bus_write(4, 6); bus_read(4, d); check("R10 full clear", d, 0);
    idle(2);
    check("R11 irq drops", int'(irq), 0);
    // R9 duty zero: only the clear source fires
    setup(5, 0, 0, 0, 1'b1);
    bus_write(4, 7);
    idle(100);
    bus_read(4, d); check("R9 clear source only", d, 4);
    bus_write(0, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule